// File: doc/BRIEF.md
# Phase-Current Accumulating Sampler

This block sits between a serial ADC front end and a host processor in a three-phase motor drive. Each time the front end presents a valid conversion result tagged with a channel index, the block adds the unsigned sample into a free-running sum for that phase current. The sums never clear after reset. A host that reads a sum twice divides the difference between the two reads by the difference between two reads of the conversion-cycle counter, and so gets the mean current over the interval. It can read at any rate and no samples are lost.

A conversion-cycle counter advances once every channel has contributed at least one sample since the previous advance. The counter is packed into a status word together with the three Hall sensor levels, three phase-driver fault flags and a power-present flag. These seven level inputs are asynchronous, so each passes through a two-stage synchronizer first. A single snapshot strobe copies all three sums and the status word into output registers on the same edge. The host therefore always sees values that belong together.

Top module: `phase_current_accumulator`

## Requirements
- R1: After synchronous reset, all three snapshot sums and the snapshot status word read zero. The internal sums and the cycle counter also restart from zero, so the first snapshot after reset reflects only the samples accepted since then.
- R2: A sample accepted with `sample_valid` high and `sample_chan` equal to 0, 1 or 2 is added to the sum of phase A, B or C respectively. No other sum changes. A sample tagged with channel code 3 changes nothing.
- R3: Each sum is 24 bits wide and wraps modulo 2^24. The 12-bit sample is zero-extended before it is added.
- R4: The cycle counter increments by exactly one on the edge where the last missing channel of a sequence is added. A second sample on a channel already seen in the current sequence is summed but does not complete the sequence.
- R5: The cycle counter is 9 bits wide and wraps from 511 to 0.
- R6: Status word layout: bits 8:0 hold the cycle counter. Bits 16, 17 and 18 hold Hall inputs 0, 1 and 2. Bits 20, 21 and 22 hold fault inputs 0, 1 and 2. Bit 24 holds the power-present input.
- R7: All other status bits read zero.
- R8: Hall, fault and power inputs pass through two flip-flops. Suppose an input changes before clock edge k. A snapshot taken on edge k+1 still shows the old level, and a snapshot taken on edge k+2 shows the new level.
- R9: A strobe on an edge copies all three sums and the status word as they stood before that edge. A sample accepted on the same edge does not appear in that snapshot. Without a strobe, the snapshot outputs hold their values.
- R10: With `sample_valid` low, the sample lines have no effect on any sum or on the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_valid | input | 1 | Sample present this cycle |
| sample_chan | input | 2 | Channel index of the sample (0..2, 3 ignored) |
| sample_data | input | 12 | Unsigned conversion result |
| hall_in | input | 3 | Hall sensor levels, asynchronous |
| fault_in | input | 3 | Phase-driver fault flags, asynchronous |
| power_in | input | 1 | Power-present flag, asynchronous |
| snap_strobe | input | 1 | Copy sums and status into the snapshot registers |
| snap_sum_a | output | 24 | Snapshot of phase A sum |
| snap_sum_b | output | 24 | Snapshot of phase B sum |
| snap_sum_c | output | 24 | Snapshot of phase C sum |
| snap_status | output | 32 | Snapshot of packed status word |

## Verification
Every internal register reaches the ports only through the snapshot stage, one edge after a strobe. The bench therefore strobes after each stimulus, and a corrupted sum, counter or sequence mask becomes visible in the very next snapshot. A sample routed to the wrong channel, or dropped, changes a sum by exactly that sample's value. A wrong sequence-mask rule shows up as the counter advancing one sample early or late. A missing or extra synchronizer stage moves the edge at which a Hall or fault change appears by one cycle.

// File: rtl/pca_pkg.sv
package pca_pkg;
    localparam int NCH      = 3;
    localparam int CHAN_W   = 2;
    localparam int SAMPLE_W = 12;
    localparam int SUM_W    = 24;
    localparam int CNT_W    = 9;
    localparam int NLVL     = 3;
    localparam int STAT_W   = 32;
    localparam int CNT_LSB  = 0;
    localparam int HALL_LSB = 16;
    localparam int FLT_LSB  = 20;
    localparam int PWR_BIT  = 24;
    localparam int SYNC_W   = 2 * NLVL + 1;

    typedef logic [SUM_W-1:0]  sum_t;
    typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/pca_sync.sv
module pca_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign dout = st_q.s2;

    // R8: output equals the input two edges earlier
    assert_sync_delay_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!rst, 2)) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/pca_chan_acc.sv
module pca_chan_acc #(
    parameter int SAMPLE_W = pca_pkg::SAMPLE_W,
    parameter int SUM_W    = pca_pkg::SUM_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                add_en,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [SUM_W-1:0]    sum_o
);
    localparam int PAD_W = SUM_W - SAMPLE_W;

    typedef struct packed {
        logic [SUM_W-1:0] sum;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [SUM_W-1:0] sample_ext;

    always_comb begin
        sample_ext = {{PAD_W{1'b0}}, sample};
        st_d       = st_q;
        if (add_en) st_d.sum = st_q.sum + sample_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sum_o = st_q.sum;

    // R2 / R3: an enabled edge adds the zero-extended sample modulo 2^SUM_W
    assert_sum_step_R3: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && add_en) |-> (sum_o == SUM_W'($past(sum_o) + {{PAD_W{1'b0}}, $past(sample)})));
    // R10: without an enable the sum holds
    assert_sum_hold_R10: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !add_en) |-> $stable(sum_o));
endmodule

// File: rtl/pca_seq_count.sv
module pca_seq_count #(
    parameter int NCH    = pca_pkg::NCH,
    parameter int CHAN_W = pca_pkg::CHAN_W,
    parameter int CNT_W  = pca_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic [CHAN_W-1:0] chan,
    output logic [CNT_W-1:0]  cnt_o
);
    typedef struct packed {
        logic [NCH-1:0]   seen;
        logic [CNT_W-1:0] cnt;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic [NCH-1:0] seen_upd;

    always_comb begin
        st_d     = st_q;
        seen_upd = st_q.seen;
        for (int i = 0; i < NCH; i++) begin
            if (valid && (chan == CHAN_W'(i))) seen_upd[i] = 1'b1;
        end
        if (&seen_upd) begin
            st_d.seen = '0;
            st_d.cnt  = st_q.cnt + 1'b1;
        end else begin
            st_d.seen = seen_upd;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R4 / R5: the counter only ever steps by one, wrapping at 2^CNT_W
    assert_cnt_step_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(st_q.cnt) |-> (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1)));
    // R4: a completed sequence leaves the seen mask empty
    assert_mask_clear_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(st_q.cnt) |-> (st_q.seen == '0));
    // R4: the counter cannot advance without a sample on that edge
    assert_cnt_needs_sample_R4: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !valid) |-> $stable(st_q.cnt));
endmodule

// File: rtl/phase_current_accumulator.sv
module phase_current_accumulator
    import pca_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sample_valid,
    input  logic [1:0]  sample_chan,
    input  logic [11:0] sample_data,
    input  logic [2:0]  hall_in,
    input  logic [2:0]  fault_in,
    input  logic        power_in,
    input  logic        snap_strobe,
    output logic [23:0] snap_sum_a,
    output logic [23:0] snap_sum_b,
    output logic [23:0] snap_sum_c,
    output logic [31:0] snap_status
);
    localparam stat_t USED_MASK = stat_t'(((1 << CNT_W) - 1) << CNT_LSB)
                                | stat_t'(((1 << NLVL) - 1) << HALL_LSB)
                                | stat_t'(((1 << NLVL) - 1) << FLT_LSB)
                                | stat_t'(1 << PWR_BIT);

    typedef struct packed {
        sum_t [NCH-1:0] sums;
        stat_t          status;
    } snap_state_t;

    logic [SYNC_W-1:0]  lvl_raw, lvl_sync;
    logic [NCH-1:0]     add_en;
    sum_t [NCH-1:0]     live_sum;
    logic [CNT_W-1:0]   cyc_cnt;
    stat_t              live_status;
    snap_state_t        snap_d, snap_q;

    assign lvl_raw = {power_in, fault_in, hall_in};

    pca_sync #(.W(SYNC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (lvl_raw),
        .dout(lvl_sync)
    );

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_chan
            assign add_en[g] = sample_valid && (sample_chan == CHAN_W'(g));
            pca_chan_acc #(.SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W)) u_acc (
                .clk   (clk),
                .rst   (rst),
                .add_en(add_en[g]),
                .sample(sample_data),
                .sum_o (live_sum[g])
            );
        end
    endgenerate

    pca_seq_count #(.NCH(NCH), .CHAN_W(CHAN_W), .CNT_W(CNT_W)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .valid(sample_valid),
        .chan (sample_chan),
        .cnt_o(cyc_cnt)
    );

    always_comb begin
        live_status = '0;
        live_status[CNT_LSB +: CNT_W] = cyc_cnt;
        live_status[HALL_LSB +: NLVL] = lvl_sync[0 +: NLVL];
        live_status[FLT_LSB +: NLVL]  = lvl_sync[NLVL +: NLVL];
        live_status[PWR_BIT]          = lvl_sync[2*NLVL];
        snap_d = snap_q;
        if (snap_strobe) begin
            snap_d.sums   = live_sum;
            snap_d.status = live_status;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) snap_q <= '0;
        else     snap_q <= snap_d;
    end

    assign snap_sum_a  = snap_q.sums[0];
    assign snap_sum_b  = snap_q.sums[1];
    assign snap_sum_c  = snap_q.sums[2];
    assign snap_status = snap_q.status;

    // R9: a strobe captures all accumulators on the same edge
    assert_snap_load_R9: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && snap_strobe) |-> (snap_sum_a == $past(live_sum[0]) &&
                                        snap_sum_b == $past(live_sum[1]) &&
                                        snap_sum_c == $past(live_sum[2])));
    // R9: without a strobe the snapshot holds
    assert_snap_hold_R9: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !snap_strobe) |-> ($stable(snap_sum_a) && $stable(snap_sum_b) &&
                                         $stable(snap_sum_c) && $stable(snap_status)));
    // R7: unlisted status bits stay clear
    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (snap_status & ~USED_MASK) == '0);
endmodule

// File: tb/phase_current_accumulator_tb.sv
module phase_current_accumulator_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_valid = 1'b0;
    logic [1:0]  sample_chan = '0;
    logic [11:0] sample_data = '0;
    logic [2:0]  hall_in = '0;
    logic [2:0]  fault_in = '0;
    logic        power_in = 1'b0;
    logic        snap_strobe = 1'b0;
    logic [23:0] snap_sum_a, snap_sum_b, snap_sum_c;
    logic [31:0] snap_status;

    int tests = 0;
    int fails = 0;

    logic [23:0] m_sum [3];
    logic [2:0]  m_seen;
    logic [8:0]  m_cnt;
    logic [23:0] e_sum [3];
    logic [8:0]  e_cnt;

    always #10 clk = ~clk;

    phase_current_accumulator u_dut (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_chan(sample_chan),
        .sample_data(sample_data), .hall_in(hall_in), .fault_in(fault_in),
        .power_in(power_in), .snap_strobe(snap_strobe), .snap_sum_a(snap_sum_a),
        .snap_sum_b(snap_sum_b), .snap_sum_c(snap_sum_c), .snap_status(snap_status)
    );

    // {chan, data, expected count, expected sums a, b, c}
    typedef struct packed {
        logic [1:0]  ch;
        logic [11:0] d;
        logic [8:0]  cnt;
        logic [23:0] sa;
        logic [23:0] sb;
        logic [23:0] sc;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 12'd100,  9'd0, 24'd100, 24'd0,   24'd0},
        '{2'd1, 12'd200,  9'd0, 24'd100, 24'd200, 24'd0},
        '{2'd1, 12'd50,   9'd0, 24'd100, 24'd250, 24'd0},
        '{2'd2, 12'd7,    9'd1, 24'd100, 24'd250, 24'd7},
        '{2'd3, 12'd999,  9'd1, 24'd100, 24'd250, 24'd7},
        '{2'd2, 12'd4095, 9'd1, 24'd100, 24'd250, 24'd4102},
        '{2'd0, 12'd1,    9'd1, 24'd101, 24'd250, 24'd4102},
        '{2'd1, 12'd2,    9'd2, 24'd101, 24'd252, 24'd4102}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] stat_of(input logic [8:0] c, input logic [2:0] h,
                                            input logic [2:0] f, input logic p);
        return {7'd0, p, 1'b0, f, 1'b0, h, 7'd0, c};
    endfunction

    // one clock cycle of stimulus; model tracks sums, mask, counter
    task automatic step(input logic v, input logic [1:0] ch, input logic [11:0] d, input logic s);
        @(negedge clk);
        sample_valid = v; sample_chan = ch; sample_data = d; snap_strobe = s;
        if (s) begin
            for (int i = 0; i < 3; i++) e_sum[i] = m_sum[i];
            e_cnt = m_cnt;
        end
        if (v && ch != 2'd3) begin
            m_sum[ch]  = m_sum[ch] + {12'd0, d};
            m_seen[ch] = 1'b1;
            if (&m_seen) begin m_seen = '0; m_cnt = m_cnt + 1'b1; end
        end
        @(posedge clk);
        #1;
        sample_valid = 1'b0; sample_chan = '0; sample_data = '0; snap_strobe = 1'b0;
    endtask

    task automatic check_snap(input string req);
        check({req, " sum_a"}, {8'd0, snap_sum_a}, {8'd0, e_sum[0]});
        check({req, " sum_b"}, {8'd0, snap_sum_b}, {8'd0, e_sum[1]});
        check({req, " sum_c"}, {8'd0, snap_sum_c}, {8'd0, e_sum[2]});
        check({req, " status"}, snap_status, stat_of(e_cnt, hall_in, fault_in, power_in));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) begin m_sum[i] = '0; e_sum[i] = '0; end
        m_seen = '0; m_cnt = '0; e_cnt = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 sum_a", {8'd0, snap_sum_a}, 32'd0);
        check("R1 sum_b", {8'd0, snap_sum_b}, 32'd0);
        check("R1 sum_c", {8'd0, snap_sum_c}, 32'd0);
        check("R1 status", snap_status, 32'd0);

        // R2 / R4 vector walk
        for (int k = 0; k < 8; k++) begin
            step(1'b1, VECS[k].ch, VECS[k].d, 1'b0);
            step(1'b0, 2'd0, 12'd0, 1'b1);
            check("R2 table sum_a", {8'd0, snap_sum_a}, {8'd0, VECS[k].sa});
            check("R2 table sum_b", {8'd0, snap_sum_b}, {8'd0, VECS[k].sb});
            check("R2 table sum_c", {8'd0, snap_sum_c}, {8'd0, VECS[k].sc});
            check("R4 table count", {23'd0, snap_status[8:0]}, {23'd0, VECS[k].cnt});
        end

        // R10: sample lines with valid low
        step(1'b0, 2'd0, 12'd123, 1'b0);
        step(1'b0, 2'd1, 12'd456, 1'b0);
        step(1'b0, 2'd0, 12'd0, 1'b1);
        check_snap("R10 valid low");

        // R9: hold without strobe, then same-edge sample excluded
        step(1'b1, 2'd0, 12'd55, 1'b0);
        check_snap("R9 hold");
        step(1'b1, 2'd2, 12'd9, 1'b1);
        check_snap("R9 same edge");
        step(1'b0, 2'd0, 12'd0, 1'b1);
        check_snap("R9 next strobe");

        // R6 / R7 status layout
        @(negedge clk);
        hall_in = 3'b101; fault_in = 3'b010; power_in = 1'b1;
        repeat (3) @(negedge clk);
        step(1'b0, 2'd0, 12'd0, 1'b1);
        check("R6 layout", snap_status, stat_of(m_cnt, 3'b101, 3'b010, 1'b1));
        check("R7 reserved", snap_status & 32'hFE88_FE00, 32'd0);
        @(negedge clk);
        hall_in = 3'b010; fault_in = 3'b101; power_in = 1'b0;
        repeat (3) @(negedge clk);
        step(1'b0, 2'd0, 12'd0, 1'b1);
        check("R6 layout inverse", snap_status, stat_of(m_cnt, 3'b010, 3'b101, 1'b0));

        // R8 synchronizer latency: change before edge k, strobe at k+1 and k+2
        @(negedge clk);
        hall_in = 3'b111; fault_in = 3'b111; power_in = 1'b1;
        @(negedge clk);
        snap_strobe = 1'b1;
        @(posedge clk); #1 snap_strobe = 1'b0;
        check("R8 old level", snap_status, stat_of(m_cnt, 3'b010, 3'b101, 1'b0));
        @(negedge clk);
        snap_strobe = 1'b1;
        @(posedge clk); #1 snap_strobe = 1'b0;
        check("R8 new level", snap_status, stat_of(m_cnt, 3'b111, 3'b111, 1'b1));

        // R5 counter wrap 511 -> 0
        while (m_cnt != 9'd511) begin
            step(1'b1, 2'd2, 12'd1, 1'b0);
            step(1'b1, 2'd0, 12'd2, 1'b0);
            step(1'b1, 2'd1, 12'd3, 1'b0);
        end
        step(1'b0, 2'd0, 12'd0, 1'b1);
        check_snap("R5 at 511");
        step(1'b1, 2'd0, 12'd1, 1'b0);
        step(1'b1, 2'd1, 12'd1, 1'b0);
        step(1'b1, 2'd2, 12'd1, 1'b0);
        step(1'b0, 2'd0, 12'd0, 1'b1);
        check("R5 wrapped", {23'd0, snap_status[8:0]}, 32'd0);

        // R3 sum wrap on phase A
        while (m_sum[0] < 24'hFFF000) step(1'b1, 2'd0, 12'd4095, 1'b0);
        step(1'b1, 2'd0, 12'd4095, 1'b0);
        step(1'b1, 2'd0, 12'd4095, 1'b0);
        step(1'b0, 2'd0, 12'd0, 1'b1);
        check_snap("R3 wrap");
        check("R3 below start", {31'd0, (snap_sum_a < 24'h002000)}, 32'd1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule